// File: doc/BRIEF.md
# Floppy Adapter Host Port Front End

This block is the byte-wide register front end of a floppy disk adapter that presents two channels to a host I/O bus: a double-density channel at window offsets 0 to 15 and a single-density channel at offsets 16 to 31. Both channels share one register layout. A host reads a status byte, a result type and a result byte. It writes the two bytes of a parameter-block address, and the write of the high byte starts a command. A write to the reset port rebuilds the subsystem state.

A command engine, outside this block, receives a one-cycle start pulse with the 16-bit address and the channel. It reports completion with a strobe that carries an error field and the interrupt-control code taken from the command's channel word. The block keeps one interrupt flip-flop per channel and a sticky ready bit per drive. When a drive-present input rises, the new drive is reported through a ready-change form of the result byte.

Top module: `fdc_host_port`

## Requirements
- R1: Double-density status (offset 0) reads {0, ready3, ready2, 1, 1, intff, ready1, ready0}: bit 7 is 0, bit 4 (double density) and bit 3 (present) are 1, and bit 2 is that channel's interrupt flip-flop.
- R2: Single-density status (offset 16) reads {0, 0, 0, 0, 1, intff, sd_ready1, sd_ready0`}`: bits 7 to 4 are 0 and bit 3 is 1. Offsets 17, 18, 19 and 23 act on the single-density channel as 1, 2, 3 and 7 do on the double-density channel.
- R3: Offset 1 (or 17) reads the channel's result type in bits 1:0 with bits 7:2 zero. Type 0 is completion with an error field and type 2 is ready-change.
- R4: A read of offset 1 (or 17) clears that channel's interrupt flip-flop at the same clock edge, so status bit 2 reads 0 from the next cycle.
- R5: A write to offset 1 latches the channel's low address byte. A write to offset 2 drives `eng_start` high for exactly the following cycle, with `eng_pb_addr` = {written byte, latched low byte} and `eng_chan` = 0 for double density and 1 for single density.
- R6: An `eng_done` strobe for a channel sets its interrupt flip-flop, sets its result type to 0, stores `eng_done_err` as its error field and latches `eng_done_icw`.
- R7: Offset 3 (or 19) returns the error field whenever no ready-change report is pending on the channel. The error bits are: 0 deleted record, 1 CRC, 2 seek, 3 address, 4 overrun, 5 write protect, 6 write error, 7 not ready.
- R8: A rising drive-present input sets that drive's ready bit and puts both channels in type 2 with a report pending. Offset 3 with type 2 and a report pending returns {ready1, ready0, ready3, ready2, 0000} on the double-density channel and {sd_ready1, sd_ready0, 000000} on the single-density channel. That read clears the pending report and returns the type to 0. A falling present input leaves the ready bits unchanged. After reset the ready bits are 0.
- R9: `irq` is high exactly when some channel has its interrupt flip-flop set and its latched control code equal to 00.
- R10: A write to offset 7 (or 23) sets both channels to type 0 with error field 0, clears the pending reports and the interrupt flip-flops, and loads the ready bits from the present inputs. It overrides a completion in the same cycle.
- R11: `io_rdata` is 0 when `io_rd` is low and for offsets 2 and 4 to 15 of either channel. Writes to offsets other than 1, 2 and 7 change nothing.
- R12: A completion and a read of the result type on the same channel in the same cycle leave the interrupt flip-flop set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 5 | Port offset; bit 4 selects the single-density channel |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational |
| drv_present_dd | input | 4 | Double-density drives present |
| drv_present_sd | input | 2 | Single-density drives present |
| eng_start | output | 1 | One-cycle command start |
| eng_chan | output | 1 | Channel of the started command |
| eng_pb_addr | output | 16 | Parameter-block address |
| eng_done | input | 1 | Completion strobe |
| eng_done_chan | input | 1 | Channel of the completion |
| eng_done_err | input | 8 | Error field of the completion |
| eng_done_icw | input | 2 | Interrupt-control code of the command |
| irq | output | 1 | Interrupt request |

## Verification
The block has no parameters, so the bench builds its single fixed shape with both channels live. A behavioural model runs beside it and drives ready-change reports from a partial drive population, completions with masked and unmasked control codes, and reset-port writes that collide with completions. These cases bring each branch of the result-byte multiplexer and every priority between the per-channel updates within reach.

// File: rtl/fdc_host_port.sv
module fdc_host_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  io_addr,
  input  logic        io_rd,
  input  logic        io_wr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [3:0]  drv_present_dd,
  input  logic [1:0]  drv_present_sd,
  output logic        eng_start,
  output logic        eng_chan,
  output logic [15:0] eng_pb_addr,
  input  logic        eng_done,
  input  logic        eng_done_chan,
  input  logic [7:0]  eng_done_err,
  input  logic [1:0]  eng_done_icw,
  output logic        irq
);

  localparam logic [3:0] OFF_STAT = 4'd0;
  localparam logic [3:0] OFF_TYPE = 4'd1;
  localparam logic [3:0] OFF_GO   = 4'd2;
  localparam logic [3:0] OFF_RES  = 4'd3;
  localparam logic [3:0] OFF_RST  = 4'd7;
  localparam logic [1:0] TYPE_ERR = 2'd0;
  localparam logic [1:0] TYPE_RDY = 2'd2;

  logic       ch;
  logic [3:0] off;
  assign ch  = io_addr[4];
  assign off = io_addr[3:0];

  logic [3:0] rdy_dd, prev_dd;
  logic [1:0] rdy_sd, prev_sd;
  logic [1:0] intff, pend;
  logic [1:0] rtype_q [2];
  logic [7:0] err_q   [2];
  logic [7:0] lo_q    [2];
  logic [1:0] icw_q   [2];

  logic any_rise, rst_port;
  assign any_rise = |(drv_present_dd & ~prev_dd) | |(drv_present_sd & ~prev_sd);
  assign rst_port = io_wr && off == OFF_RST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_dd      <= '0;
      rdy_sd      <= '0;
      prev_dd     <= '0;
      prev_sd     <= '0;
      intff       <= '0;
      pend        <= '0;
      eng_start   <= 1'b0;
      eng_chan    <= 1'b0;
      eng_pb_addr <= '0;
      for (int c = 0; c < 2; c++) begin
        rtype_q[c] <= TYPE_ERR;
        err_q[c]   <= '0;
        lo_q[c]    <= '0;
        icw_q[c]   <= '0;
      end
    end else begin
      eng_start <= 1'b0;
      prev_dd   <= drv_present_dd;
      prev_sd   <= drv_present_sd;
      rdy_dd    <= rdy_dd | drv_present_dd;
      rdy_sd    <= rdy_sd | drv_present_sd;
      for (int c = 0; c < 2; c++) begin
        if (io_rd && ch == c[0] && off == OFF_RES && rtype_q[c] == TYPE_RDY && pend[c]) begin
          pend[c]    <= 1'b0;
          rtype_q[c] <= TYPE_ERR;
        end
        if (io_rd && ch == c[0] && off == OFF_TYPE)
          intff[c] <= 1'b0;
        if (any_rise) begin
          pend[c]    <= 1'b1;
          rtype_q[c] <= TYPE_RDY;
        end
        if (eng_done && eng_done_chan == c[0]) begin
          intff[c]   <= 1'b1;
          rtype_q[c] <= TYPE_ERR;
          err_q[c]   <= eng_done_err;
          icw_q[c]   <= eng_done_icw;
        end
        if (io_wr && ch == c[0] && off == OFF_TYPE)
          lo_q[c] <= io_wdata;
        if (rst_port) begin
          intff[c]   <= 1'b0;
          pend[c]    <= 1'b0;
          rtype_q[c] <= TYPE_ERR;
          err_q[c]   <= '0;
        end
      end
      if (io_wr && off == OFF_GO) begin
        eng_start   <= 1'b1;
        eng_chan    <= ch;
        eng_pb_addr <= {io_wdata, lo_q[ch]};
      end
      if (rst_port) begin
        rdy_dd <= drv_present_dd;
        rdy_sd <= drv_present_sd;
      end
    end
  end

  logic [7:0] stat_dd, stat_sd, chg_dd, chg_sd, rd_val;
  assign stat_dd = {1'b0, rdy_dd[3], rdy_dd[2], 1'b1, 1'b1, intff[0], rdy_dd[1], rdy_dd[0]};
  assign stat_sd = {4'b0, 1'b1, intff[1], rdy_sd[1], rdy_sd[0]};
  assign chg_dd  = {rdy_dd[1], rdy_dd[0], rdy_dd[3], rdy_dd[2], 4'b0};
  assign chg_sd  = {rdy_sd[1], rdy_sd[0], 6'b0};

  always_comb begin
    rd_val = '0;
    case (off)
      OFF_STAT: rd_val = ch ? stat_sd : stat_dd;
      OFF_TYPE: rd_val = {6'b0, rtype_q[ch]};
      OFF_RES:  rd_val = (rtype_q[ch] == TYPE_RDY && pend[ch]) ? (ch ? chg_sd : chg_dd) : err_q[ch];
      default:  rd_val = '0;
    endcase
  end

  assign io_rdata = io_rd ? rd_val : 8'h00;
  assign irq = (intff[0] && icw_q[0] == 2'b00) || (intff[1] && icw_q[1] == 2'b00);

  p_stat_b7_r1: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && off == OFF_STAT |-> !io_rdata[7]);

  p_type_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd && !ch && off == OFF_TYPE && !eng_done && !rst_port |=> !intff[0]);

  p_start_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(io_wr) && $past(io_addr[3:0]) == OFF_GO);

  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && eng_done_chan && !rst_port |=> intff[1] && rtype_q[1] == TYPE_ERR);

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> intff != 2'b00);

  p_rst_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_port |=> intff == 2'b00 && pend == 2'b00);

endmodule

// File: tb/fdc_host_port_test.sv
`timescale 1ns/100ps
module fdc_host_port_test;
  logic clk = 0, rst_n = 0;
  logic [4:0] io_addr = 0;
  logic io_rd = 0, io_wr = 0;
  logic [7:0] io_wdata = 0, io_rdata;
  logic [3:0] drv_present_dd = 0;
  logic [1:0] drv_present_sd = 0;
  logic eng_start, eng_chan, irq;
  logic [15:0] eng_pb_addr;
  logic eng_done = 0, eng_done_chan = 0;
  logic [7:0] eng_done_err = 0;
  logic [1:0] eng_done_icw = 0;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fdc_host_port uut (.*);

  // behavioural reference model
  bit m_rdy [6];
  bit m_prev [6];
  bit m_int [2], m_pend [2];
  int m_type [2], m_err [2], m_lo [2], m_icw [2];
  bit m_start; int m_chan, m_pb;

  function automatic bit pres(int i);
    return i < 4 ? drv_present_dd[i] : drv_present_sd[i-4];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) begin m_rdy[i] = 0; m_prev[i] = 0; end
      for (int c = 0; c < 2; c++) begin
        m_int[c] = 0; m_pend[c] = 0; m_type[c] = 0; m_err[c] = 0; m_lo[c] = 0; m_icw[c] = 0;
      end
      m_start = 0; m_chan = 0; m_pb = 0;
    end else begin
      int c, o; bit rise, rp;
      c = io_addr[4]; o = io_addr[3:0];
      rise = 0;
      for (int i = 0; i < 6; i++) if (pres(i) && !m_prev[i]) rise = 1;
      rp = io_wr && o == 7;
      m_start = 0;
      if (io_wr && o == 2) begin m_start = 1; m_chan = c; m_pb = io_wdata * 256 + m_lo[c]; end
      if (io_rd && o == 3 && m_type[c] == 2 && m_pend[c]) begin m_pend[c] = 0; m_type[c] = 0; end
      if (io_rd && o == 1) m_int[c] = 0;
      if (rise) for (int k = 0; k < 2; k++) begin m_pend[k] = 1; m_type[k] = 2; end
      if (eng_done) begin
        m_int[eng_done_chan] = 1; m_type[eng_done_chan] = 0;
        m_err[eng_done_chan] = eng_done_err; m_icw[eng_done_chan] = eng_done_icw;
      end
      if (io_wr && o == 1) m_lo[c] = io_wdata;
      for (int i = 0; i < 6; i++) begin
        if (pres(i)) m_rdy[i] = 1;
        if (rp) m_rdy[i] = pres(i);
        m_prev[i] = pres(i);
      end
      if (rp) for (int k = 0; k < 2; k++) begin m_int[k] = 0; m_pend[k] = 0; m_type[k] = 0; m_err[k] = 0; end
    end
  end

  function automatic int m_read();
    int c, o, v;
    c = io_addr[4]; o = io_addr[3:0]; v = 0;
    if (!io_rd) return 0;
    if (o == 0) begin
      v = 8 + 4 * m_int[c];
      if (c == 0) v += 16 + m_rdy[0] + 2 * m_rdy[1] + 32 * m_rdy[2] + 64 * m_rdy[3];
      else v += m_rdy[4] + 2 * m_rdy[5];
    end else if (o == 1) v = m_type[c];
    else if (o == 3) begin
      if (m_type[c] == 2 && m_pend[c]) begin
        if (c == 0) v = 16 * m_rdy[2] + 32 * m_rdy[3] + 64 * m_rdy[0] + 128 * m_rdy[1];
        else v = 64 * m_rdy[4] + 128 * m_rdy[5];
      end else v = m_err[c];
    end
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int exp_irq;
    #1;
    case (io_addr[3:0])
      4'd0: check("R1", io_rdata, m_read());
      4'd1: check("R3", io_rdata, m_read());
      4'd3: check("R7", io_rdata, m_read());
      default: check("R11", io_rdata, m_read());
    endcase
    exp_irq = (m_int[0] && m_icw[0] == 0) || (m_int[1] && m_icw[1] == 0);
    check("R9", irq, exp_irq);
    check("R5", eng_start, m_start);
    if (m_start) begin check("R5", eng_pb_addr, m_pb); check("R5", eng_chan, m_chan); end
  end

  task automatic rd(input logic [4:0] a, output int v);
    @(negedge clk); io_rd = 1; io_addr = a; #1 v = io_rdata;
    @(negedge clk); io_rd = 0;
  endtask

  task automatic rdc(logic [4:0] a, int exp, string tag);
    int v; rd(a, v); check(tag, v, exp);
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic done(bit ch, logic [7:0] err, logic [1:0] icw, bit with_rd, bit with_rst);
    @(negedge clk);
    eng_done = 1; eng_done_chan = ch; eng_done_err = err; eng_done_icw = icw;
    if (with_rd) begin io_rd = 1; io_addr = {ch, 4'd1}; end
    if (with_rst) begin io_wr = 1; io_addr = 5'd7; end
    @(negedge clk); eng_done = 0; io_rd = 0; io_wr = 0;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rdc(5'd0, 8'h18, "R1 reset");
    rdc(5'd16, 8'h08, "R2 reset");
    rdc(5'd1, 0, "R3 reset");
    check("R9 reset", irq, 0);
    // drives 0 and 2 on DD, drive 1 on SD appear
    @(negedge clk); drv_present_dd = 4'b0101; drv_present_sd = 2'b10;
    rdc(5'd0, 8'h39, "R1 ready");
    rdc(5'd16, 8'h0A, "R2 ready");
    rdc(5'd1, 2, "R3 type ready-change");
    rdc(5'd3, 8'h50, "R8 dd layout");
    rdc(5'd1, 0, "R8 pending cleared");
    rdc(5'd19, 8'h80, "R8 sd layout");
    rdc(5'd19, 8'h00, "R7 after report");
    @(negedge clk); drv_present_dd = 4'b0001;
    rdc(5'd0, 8'h39, "R8 falling ignored");
    rdc(5'd1, 0, "R8 falling no report");
    // command starts
    wr(5'd1, 8'h34); wr(5'd2, 8'h12);
    #1 check("R5 start", eng_start, 1); check("R5 addr", eng_pb_addr, 16'h1234); check("R5 chan", eng_chan, 0);
    @(negedge clk); #1 check("R5 one cycle", eng_start, 0);
    wr(5'd17, 8'hCD); wr(5'd18, 8'hAB);
    #1 check("R2 sd start", eng_pb_addr, 16'hABCD); check("R5 sd chan", eng_chan, 1);
    // completions
    done(0, 8'h08, 2'b00, 0, 0);
    #1 check("R9 irq enabled", irq, 1);
    rdc(5'd0, 8'h3D, "R6 intff");
    rdc(5'd3, 8'h08, "R7 address error");
    rdc(5'd1, 0, "R6 type");
    rdc(5'd0, 8'h39, "R4 cleared");
    check("R4 irq low", irq, 0);
    done(1, 8'h80, 2'b01, 0, 0);
    #1 check("R9 masked", irq, 0);
    rdc(5'd16, 8'h0E, "R2 sd intff");
    rdc(5'd19, 8'h80, "R7 not ready");
    rdc(5'd17, 0, "R4 sd type");
    rdc(5'd16, 8'h0A, "R4 sd cleared");
    done(1, 8'h20, 2'b00, 0, 0);
    #1 check("R9 sd irq", irq, 1);
    // writes to other offsets do nothing
    wr(5'd3, 8'hFF); wr(5'd5, 8'hFF);
    rdc(5'd19, 8'h20, "R11 write ignored");
    rdc(5'd5, 0, "R11 unused offset");
    rdc(5'd2, 0, "R11 offset 2 read");
    // reset port
    wr(5'd7, 8'h00);
    #1 check("R10 irq", irq, 0);
    rdc(5'd0, 8'h19, "R10 dd rebuild");
    rdc(5'd16, 8'h0A, "R10 sd rebuild");
    rdc(5'd19, 0, "R10 err clear");
    done(0, 8'h40, 2'b00, 0, 1);
    rdc(5'd0, 8'h19, "R10 overrides done");
    rdc(5'd3, 0, "R10 err wins");
    done(0, 8'h02, 2'b00, 1, 0);
    rdc(5'd0, 8'h1D, "R12 done wins");
    #1 check("R12 irq", irq, 1);
    @(negedge clk); #1 check("R11 no read", io_rdata, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule